// File: doc/BRIEF.md
# Indirect Register Access Verb Bridge

This block sits behind a vendor control node on an audio-codec command bus. A host sends it 12-bit verb codes, each carrying a 16-bit argument. It answers every verb with a 32-bit response one clock later. The bridge builds a 32-bit internal address and a 32-bit write word out of 16-bit halves. It runs single writes and posted reads on a simple internal memory-mapped bus that uses a request/ready handshake.

Bus latency varies, so the host drives each access in steps. First it loads the address halves. For a write it then loads the data halves, and loading the upper data half starts the write. For a read it sends a post command instead. After either, it polls a status verb until the status reads OK. After a read completes, a separate verb fetches the captured word. While an access is outstanding, every verb that would change the held address or data, or start another access, is refused with a busy answer and has no effect.

Top module: `verb_bridge`

## Requirements
- R1: After reset, the address, write-data and read-capture registers are zero, no bus request is active, and status verb 0xF01 answers 0 (OK).
- R2: Verb 0x000 loads address bits 15:0 and verb 0x100 loads address bits 31:16 from the argument. An accepted load answers 0.
- R3: Verb 0x300 loads write-data bits 15:0. Verb 0x400 loads bits 31:16 and starts a bus write (bus_we=1) of the held data word to the held address. Both answer 0 when accepted.
- R4: Verb 0x702 starts a bus read (bus_we=0) at the held address. The bus_rdata value present in the cycle bus_ready completes the read is captured, and verb 0xF03 returns the captured word.
- R5: Verb 0xF01 answers 1 (busy) from the cycle after an access starts through the cycle in which bus_ready completes it. It answers 0 from the next cycle on.
- R6: bus_req stays high, with bus_addr, bus_wdata and bus_we stable, from the start of an access until bus_ready is sampled high.
- R7: While an access is outstanding, verbs 0x000, 0x100, 0x300, 0x400 and 0x702 answer 1 and leave the held address, held data and bus activity unchanged.
- R8: Any other verb code answers 0 and has no effect on registers or on the bus.
- R9: rsp_valid is high in exactly the cycle after each cycle in which vrb_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vrb_valid | input | 1 | Verb present this cycle |
| vrb_code | input | 12 | Verb code |
| vrb_arg | input | 16 | Verb argument |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Response word |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Internal address |
| bus_wdata | output | 32 | Internal write data |
| bus_ready | input | 1 | Access completed this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |

## Verification
The bench sweeps bus latencies from 0 to 3 wait cycles across a set of addresses and data words. The upper and lower halves of each word differ, so a swapped or stale half shows up on the bus. At each latency it counts the exact number of busy answers before OK, which separates an early or late clear of the busy state from a correct one. Refused loads are sent in the middle of a slow access and then exposed by the next accesses, which must still carry the old address and data. Unknown codes, including one that differs from a valid verb by a single bit, must leave bus activity and the captured read word unchanged.

// File: rtl/verb_bridge.sv
module verb_bridge #(
  parameter int HALF_W = 16,
  parameter int CODE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vrb_valid,
  input  logic [CODE_W-1:0]   vrb_code,
  input  logic [HALF_W-1:0]   vrb_arg,
  output logic                rsp_valid,
  output logic [2*HALF_W-1:0] rsp_data,
  output logic                bus_req,
  output logic                bus_we,
  output logic [2*HALF_W-1:0] bus_addr,
  output logic [2*HALF_W-1:0] bus_wdata,
  input  logic                bus_ready,
  input  logic [2*HALF_W-1:0] bus_rdata
);
  localparam int FULL_W = 2 * HALF_W;
  localparam logic [CODE_W-1:0] V_ADR_LO = CODE_W'('h000);
  localparam logic [CODE_W-1:0] V_ADR_HI = CODE_W'('h100);
  localparam logic [CODE_W-1:0] V_DAT_LO = CODE_W'('h300);
  localparam logic [CODE_W-1:0] V_DAT_HI = CODE_W'('h400);
  localparam logic [CODE_W-1:0] V_POST   = CODE_W'('h702);
  localparam logic [CODE_W-1:0] V_STAT   = CODE_W'('hF01);
  localparam logic [CODE_W-1:0] V_FETCH  = CODE_W'('hF03);
  localparam logic [FULL_W-1:0] ST_OK    = FULL_W'(0);
  localparam logic [FULL_W-1:0] ST_BUSY  = FULL_W'(1);

  logic [FULL_W-1:0] addr_q, data_q, cap_q, rsp_q;
  logic              pend_q, we_q, rv_q;

  wire [FULL_W-1:0] st_now = pend_q ? ST_BUSY : ST_OK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      cap_q  <= '0;
      rsp_q  <= '0;
      pend_q <= 1'b0;
      we_q   <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      rv_q <= vrb_valid;
      if (pend_q && bus_ready) begin
        pend_q <= 1'b0;
        if (!we_q) cap_q <= bus_rdata;
      end
      if (vrb_valid) begin
        case (vrb_code)
          V_ADR_LO: begin
            if (!pend_q) addr_q[HALF_W-1:0] <= vrb_arg;
            rsp_q <= st_now;
          end
          V_ADR_HI: begin
            if (!pend_q) addr_q[FULL_W-1:HALF_W] <= vrb_arg;
            rsp_q <= st_now;
          end
          V_DAT_LO: begin
            if (!pend_q) data_q[HALF_W-1:0] <= vrb_arg;
            rsp_q <= st_now;
          end
          V_DAT_HI: begin
            if (!pend_q) begin
              data_q[FULL_W-1:HALF_W] <= vrb_arg;
              pend_q <= 1'b1;
              we_q   <= 1'b1;
            end
            rsp_q <= st_now;
          end
          V_POST: begin
            if (!pend_q) begin
              pend_q <= 1'b1;
              we_q   <= 1'b0;
            end
            rsp_q <= st_now;
          end
          V_STAT:  rsp_q <= st_now;
          V_FETCH: rsp_q <= cap_q;
          default: rsp_q <= '0;
        endcase
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rsp_q;
  assign bus_req   = pend_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!bus_req && !rsp_valid && bus_addr == '0 && bus_wdata == '0 && cap_q == '0));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

  // R4
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ready) |=> (cap_q == $past(bus_rdata)));

  // R5
  status_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vrb_valid && vrb_code == V_STAT && bus_req) |=> (rsp_data == ST_BUSY));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_wdata)));

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vrb_valid |=> rsp_valid);

  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vrb_valid |=> !rsp_valid);
endmodule

// File: tb/verb_bridge_bench.sv
module verb_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vrb_valid = 1'b0;
  logic [11:0] vrb_code = '0;
  logic [15:0] vrb_arg = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata = '0;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int cnt = 0;
  int n_tx = 0;
  bit finished = 0;
  logic [31:0] seen_addr, seen_wdata, first_addr, first_wdata;
  logic        seen_we, first_we, in_tx = 0;

  verb_bridge u_verb_bridge (
    .clk(clk), .rst_n(rst_n), .vrb_valid(vrb_valid), .vrb_code(vrb_code),
    .vrb_arg(vrb_arg), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus responder: ready after lat extra cycles, checks R6 hold
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      in_tx = 1'b0;
    end else if (bus_req) begin
      if (!in_tx) begin
        in_tx = 1'b1;
        first_addr = bus_addr; first_wdata = bus_wdata; first_we = bus_we;
      end
      if (cnt == lat) begin
        chk(bus_addr == first_addr && bus_wdata == first_wdata && bus_we == first_we,
            "R6 hold", bus_addr, first_addr);
        bus_ready = 1'b1;
        bus_rdata = mem_f(bus_addr);
        seen_addr = bus_addr; seen_wdata = bus_wdata; seen_we = bus_we;
        n_tx++;
        cnt = 0;
      end else cnt++;
    end
  end

  task automatic send(input logic [11:0] c, input logic [15:0] a, output logic [31:0] r);
    vrb_valid = 1'b1; vrb_code = c; vrb_arg = a;
    @(negedge clk);
    vrb_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R9 valid", 32'(rsp_valid), 1);
    r = rsp_data;
  endtask

  task automatic expect_verb(input logic [11:0] c, input logic [15:0] a, input logic [31:0] e, input string tag);
    logic [31:0] r;
    send(c, a, r);
    chk(r === e, tag, r, e);
  endtask

  task automatic poll(input int exp_busy, input string tag);
    logic [31:0] r;
    int busy = 0;
    for (int k = 0; k < 50; k++) begin
      send(12'hF01, 16'h0, r);
      if (r == 32'h0) break;
      busy++;
    end
    chk(busy == exp_busy, tag, 32'(busy), 32'(exp_busy));
  endtask

  task automatic load_addr(input logic [31:0] a);
    expect_verb(12'h000, a[15:0], 0, "R2 addr lo ack");
    expect_verb(12'h100, a[31:16], 0, "R2 addr hi ack");
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", c_dummy(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
  function automatic int c_dummy(); return 150000; endfunction

  initial begin
    logic [31:0] r;
    int tx0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_req === 1'b0, "R1 no req", 32'(bus_req), 0);
    chk(rsp_valid === 1'b0, "R9 idle", 32'(rsp_valid), 0);
    expect_verb(12'hF01, 0, 0, "R1 status ok");
    expect_verb(12'hF03, 0, 0, "R1 capture zero");
    lat = 0;
    expect_verb(12'h702, 0, 0, "R4 post ack");
    poll(1, "R5 busy count");
    chk(seen_addr === 32'h0 && seen_we === 1'b0, "R1 addr zero", seen_addr, 0);
    expect_verb(12'hF03, 0, mem_f(0), "R4 fetch");

    // sweep latencies and patterns
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] a, d;
        a = (32'(i) * 32'h0101_0473) ^ (32'(l) << 28) ^ 32'h8000_0001;
        d = ~a + 32'(i * 7919);
        lat = l;
        load_addr(a);
        expect_verb(12'h300, d[15:0], 0, "R3 data lo ack");
        expect_verb(12'h400, d[31:16], 0, "R3 data hi ack");
        poll(l + 1, "R5 write busy count");
        chk(seen_addr === a, "R3 write addr", seen_addr, a);
        chk(seen_wdata === d, "R3 write data", seen_wdata, d);
        chk(seen_we === 1'b1, "R3 write we", 32'(seen_we), 1);
        expect_verb(12'h702, 0, 0, "R4 post ack");
        poll(l + 1, "R5 read busy count");
        chk(seen_we === 1'b0 && seen_addr === a, "R4 read addr", seen_addr, a);
        expect_verb(12'hF03, 0, mem_f(a), "R4 fetch");
      end
    end

    // R7: refused verbs during a slow access
    lat = 3;
    load_addr(32'h1234_ABCD);
    expect_verb(12'h300, 16'h5566, 0, "R3 data lo ack");
    expect_verb(12'h400, 16'h7788, 0, "R3 data hi ack");
    tx0 = n_tx;
    expect_verb(12'h000, 16'hFFFF, 1, "R7 addr lo refused");
    expect_verb(12'h100, 16'hEEEE, 1, "R7 addr hi refused");
    expect_verb(12'h300, 16'hDDDD, 1, "R7 data lo refused");
    expect_verb(12'h400, 16'hCCCC, 1, "R7 data hi refused");
    poll(0, "R5 cleared after lat");
    chk(n_tx == tx0 + 1, "R7 single access", 32'(n_tx), 32'(tx0 + 1));
    lat = 1;
    expect_verb(12'h702, 0, 0, "R4 post ack");
    expect_verb(12'h702, 0, 1, "R7 post refused");
    poll(1, "R5 read busy after refused post");
    chk(seen_addr === 32'h1234_ABCD, "R7 addr kept", seen_addr, 32'h1234_ABCD);
    chk(n_tx == tx0 + 2, "R7 post no access", 32'(n_tx), 32'(tx0 + 2));
    expect_verb(12'h400, 16'h7788, 0, "R3 data hi ack");
    poll(2, "R5 busy count");
    chk(seen_wdata === 32'h7788_5566, "R7 data kept", seen_wdata, 32'h7788_5566);

    // R8: unknown codes
    tx0 = n_tx;
    expect_verb(12'h200, 16'h1111, 0, "R8 unknown 200");
    expect_verb(12'h703, 16'h2222, 0, "R8 unknown 703");
    expect_verb(12'hF02, 16'h3333, 0, "R8 unknown F02");
    expect_verb(12'h001, 16'h4444, 0, "R8 unknown 001");
    @(negedge clk);
    chk(bus_req === 1'b0 && n_tx == tx0, "R8 no bus", 32'(n_tx), 32'(tx0));
    chk(rsp_valid === 1'b0, "R9 idle after gap", 32'(rsp_valid), 0);
    expect_verb(12'hF03, 0, mem_f(32'h1234_ABCD), "R8 capture kept");
    expect_verb(12'h702, 0, 0, "R4 post ack");
    poll(2, "R5 busy count");
    chk(seen_addr === 32'h1234_ABCD, "R8 addr kept", seen_addr, 32'h1234_ABCD);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule